// File: doc/BRIEF.md
# Baseband Transmit Serializer

This block moves a packet from the MAC's transmit buffer to an external radio baseband as a serial bit stream. Bytes arrive on a valid/ready stream port with a last-byte marker. Bits leave on a single data line. Everything runs on the transmit clock that the baseband supplies, and the data line changes only on that clock's rising edge.

A start request launches a transfer, and the block walks through fixed steps. It first checks the channel, where the busy input is active high and a 0 means the medium is free. It then raises the transmitter power enable and waits for the baseband's ready input. Next it shifts each byte out least significant bit first. Finally it drops the power enable and reports completion. A busy channel aborts the attempt with a busy pulse. A buffer that runs dry between bytes aborts with an underrun pulse.

Both the channel and ready inputs pass through two-flop synchronizers before use. A separate registered output holds the baseband in reset.

Back-pressure on the stream port works as follows. A byte transfers on a rising edge where `s_valid` and `s_ready` are both high. `s_ready` is raised only when the synchronized ready is high, and then only in two places: while waiting in power-up, or on the cycle the last bit of a non-final byte is on the line. A source may keep `s_valid` high for any time without loss.

Top module: `bbtx_serial_tx`

## Requirements
- R1: Each byte appears on `tx_data` least significant bit first, one bit per rising edge of `tx_clk` while synchronized ready is high.
- R2: `tx_data` is 0 whenever no byte is being shifted. It holds its value across edges where synchronized ready is low.
- R3: `start` is acted on only when the block is idle. If the synchronized channel-busy input is 1 at the check step, the block returns to idle, pulses `busy_pulse` for one cycle and never raises `tx_pwr_en`.
- R4: `tx_pwr_en` rises on the edge after a free-channel check. It stays high through power-up and shifting. Shifting of the first byte waits for synchronized ready.
- R5: `s_ready` is high only when synchronized ready is high and the block is either in power-up or on the last bit of a byte not marked last. This gives exactly one byte per 8 shifted bits.
- R6: If `s_valid` is low when the next byte of an unfinished packet is needed, the block pulses `underrun_pulse`, drops `tx_pwr_en`, forces `tx_data` to 0 and returns to idle.
- R7: One ready edge after the last bit of a byte marked last is driven, `tx_pwr_en` falls and `done_pulse` is high for exactly one cycle.
- R8: The channel-busy and ready inputs take effect two `tx_clk` rising edges after they change.
- R9: While `arst_n` is low, all state is cleared, `tx_data` and `tx_pwr_en` are 0, `bb_rst_n` is 0 and no pulse is raised.
- R10: `bb_rst_n` is the registered inverse of `bb_rst_hold`, changing one edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock from the baseband |
| arst_n | input | 1 | Asynchronous active-low reset |
| bb_rst_hold | input | 1 | Request to hold the baseband in reset |
| start | input | 1 | Transfer start request |
| cca_busy_in | input | 1 | Channel busy (1) / free (0), asynchronous |
| bb_ready_in | input | 1 | Baseband ready for data, asynchronous |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted this edge |
| s_data | input | DATA_W | Stream byte |
| s_last | input | 1 | Byte is the last of the packet |
| tx_data | output | 1 | Serial data to the baseband |
| tx_pwr_en | output | 1 | Baseband transmitter power enable |
| bb_rst_n | output | 1 | Baseband reset, active low |
| done_pulse | output | 1 | Packet completed |
| busy_pulse | output | 1 | Attempt aborted, channel busy |
| underrun_pulse | output | 1 | Attempt aborted, stream ran dry |

## Verification
The serializer is driven with several input patterns. The first is a multi-byte packet with ready held high, which separates correct bit order and byte pacing from an off-by-one in the bit counter. The second withholds ready at power-up and toggles it mid-byte; this shows whether shifting truly stalls rather than skipping or repeating bits. The third raises channel busy before a start and the fourth starves the stream after one byte; these two tell the busy abort apart from the underrun abort. Single-byte packets of all-ones and a lone set bit, a start pulse during shifting, and toggling of the baseband reset hold cover the edges of completion, start filtering and the reset output.

// File: rtl/bbtx_pkg.sv
package bbtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_PWRUP = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONE  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/bbtx_sync.sv
module bbtx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe[0] <= '0;
    else         pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) pipe[s] <= '0;
      else         pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bbtx_shifter.sv
module bbtx_shifter #(
  parameter int DATA_W = 8,
  localparam int CW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              load,
  input  logic              step,
  input  logic              clear,
  input  logic [DATA_W-1:0] din,
  output logic              tx_bit,
  output logic              last_bit
);
  logic [DATA_W-1:0] sr;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sr     <= '0;
      cnt    <= '0;
      tx_bit <= 1'b0;
    end else if (load) begin
      sr     <= din >> 1;
      cnt    <= '0;
      tx_bit <= din[0];
    end else if (step) begin
      sr     <= sr >> 1;
      cnt    <= cnt + 1'b1;
      tx_bit <= sr[0];
    end else if (clear) begin
      cnt    <= '0;
      tx_bit <= 1'b0;
    end
  end

  assign last_bit = (cnt == CW'(DATA_W - 1));

  AST_STEP_NOT_PAST_LAST: assert property (@(posedge clk) disable iff (!arst_n)
    step |-> !last_bit) else $error("shift past last bit"); // R5
  AST_LOAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!arst_n)
    load |=> !last_bit || (DATA_W == 1)) else $error("count not reset"); // R5
endmodule

// File: rtl/bbtx_ctrl.sv
module bbtx_ctrl
  import bbtx_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic start,
  input  logic cca_busy,
  input  logic bb_ready,
  input  logic s_valid,
  input  logic s_last,
  input  logic last_bit,
  input  logic tx_bit,
  output logic s_ready,
  output logic load,
  output logic step,
  output logic clear,
  output logic pwr_en,
  output logic done_pulse,
  output logic busy_pulse,
  output logic underrun_pulse
);
  tx_state_e state;
  logic      last_q;

  assign s_ready = bb_ready &&
                   ((state == ST_PWRUP) ||
                    (state == ST_SHIFT && last_bit && !last_q));
  assign load    = s_ready && s_valid;
  assign step    = (state == ST_SHIFT) && bb_ready && !last_bit;
  assign clear   = (state == ST_SHIFT) && bb_ready && last_bit && !load;
  assign done_pulse = (state == ST_DONE);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state          <= ST_IDLE;
      last_q         <= 1'b0;
      pwr_en         <= 1'b0;
      busy_pulse     <= 1'b0;
      underrun_pulse <= 1'b0;
    end else begin
      busy_pulse     <= 1'b0;
      underrun_pulse <= 1'b0;
      if (load) last_q <= s_last;
      unique case (state)
        ST_IDLE:  if (start) state <= ST_CHECK;
        ST_CHECK: begin
          if (cca_busy) begin
            state      <= ST_IDLE;
            busy_pulse <= 1'b1;
          end else begin
            state  <= ST_PWRUP;
            pwr_en <= 1'b1;
          end
        end
        ST_PWRUP: if (load) state <= ST_SHIFT;
        ST_SHIFT: begin
          if (bb_ready && last_bit) begin
            if (last_q) begin
              state  <= ST_DONE;
              pwr_en <= 1'b0;
            end else if (!s_valid) begin
              state          <= ST_IDLE;
              pwr_en         <= 1'b0;
              underrun_pulse <= 1'b1;
            end
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_PWR_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_SHIFT) |-> pwr_en) else $error("power low in shift"); // R4
  AST_LINE_LOW_OFF_SHIFT: assert property (@(posedge clk) disable iff (!arst_n)
    (state != ST_SHIFT) |-> !tx_bit) else $error("data high outside shift"); // R2
  AST_HOLD_WITHOUT_READY: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_SHIFT && !bb_ready) |=> $stable(tx_bit)) else $error("bit moved"); // R2
  AST_BUSY_NO_POWER: assert property (@(posedge clk) disable iff (!arst_n)
    busy_pulse |-> !pwr_en) else $error("power on busy abort"); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({done_pulse, busy_pulse, underrun_pulse})) else $error("two outcomes"); // R7
  AST_DONE_POWER_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    done_pulse |-> !pwr_en) else $error("power on at done"); // R7
  AST_UNDERRUN_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    underrun_pulse |-> (state == ST_IDLE) && !pwr_en) else $error("underrun exit"); // R6
endmodule

// File: rtl/bbtx_serial_tx.sv
module bbtx_serial_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tx_clk,
  input  logic              arst_n,
  input  logic              bb_rst_hold,
  input  logic              start,
  input  logic              cca_busy_in,
  input  logic              bb_ready_in,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              tx_data,
  output logic              tx_pwr_en,
  output logic              bb_rst_n,
  output logic              done_pulse,
  output logic              busy_pulse,
  output logic              underrun_pulse
);
  logic [1:0] sync_q;
  logic       load, step, clear, last_bit;

  bbtx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(tx_clk), .arst_n(arst_n),
    .d({cca_busy_in, bb_ready_in}), .q(sync_q)
  );

  bbtx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(tx_clk), .arst_n(arst_n), .load(load), .step(step), .clear(clear),
    .din(s_data), .tx_bit(tx_data), .last_bit(last_bit)
  );

  bbtx_ctrl u_ctrl (
    .clk(tx_clk), .arst_n(arst_n), .start(start),
    .cca_busy(sync_q[1]), .bb_ready(sync_q[0]),
    .s_valid(s_valid), .s_last(s_last), .last_bit(last_bit), .tx_bit(tx_data),
    .s_ready(s_ready), .load(load), .step(step), .clear(clear),
    .pwr_en(tx_pwr_en), .done_pulse(done_pulse), .busy_pulse(busy_pulse),
    .underrun_pulse(underrun_pulse)
  );

  always_ff @(posedge tx_clk or negedge arst_n) begin
    if (!arst_n) bb_rst_n <= 1'b0;
    else         bb_rst_n <= !bb_rst_hold;
  end

  AST_BB_RESET_FOLLOWS: assert property (@(posedge tx_clk) disable iff (!arst_n)
    bb_rst_hold |=> !bb_rst_n) else $error("baseband reset late"); // R10
endmodule

// File: tb/tb_bbtx_serial_tx.sv
module tb_bbtx_serial_tx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       arst_n = 1'b0, hold = 1'b0, start = 1'b0;
  logic       cca = 1'b0, rdy = 1'b0;
  logic       s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_ready, tx_data, tx_pwr_en, bb_rst_n, done_p, busy_p, und_p;

  bbtx_serial_tx dut (
    .tx_clk(clk), .arst_n(arst_n), .bb_rst_hold(hold), .start(start),
    .cca_busy_in(cca), .bb_ready_in(rdy), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .tx_data(tx_data), .tx_pwr_en(tx_pwr_en),
    .bb_rst_n(bb_rst_n), .done_pulse(done_p), .busy_pulse(busy_p),
    .underrun_pulse(und_p)
  );

  int checks = 0, fails = 0;
  int src_q[$];
  logic src_en = 1'b1;

  // behavioural reference: phase 0 idle,1 check,2 power-up,3 shift,4 done
  int   ph, idx;
  logic c0, c1, r0, r1, m_tx, m_pwr, m_busy, m_und, m_bbr, lastf;
  logic [7:0] cur;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph = 0; idx = 0; c0 = 0; c1 = 0; r0 = 0; r1 = 0; m_tx = 0; m_pwr = 0;
      m_busy = 0; m_und = 0; m_bbr = 0; lastf = 0; cur = 0;
    end else begin
      logic oc, orr, acc;
      oc = c1; orr = r1;
      c1 = c0; c0 = cca; r1 = r0; r0 = rdy;
      m_bbr = !hold; m_busy = 0; m_und = 0;
      acc = orr && s_valid && (ph == 2 || (ph == 3 && idx == 7 && !lastf));
      case (ph)
        0: if (start) ph = 1;
        1: if (oc) begin ph = 0; m_busy = 1; end else begin ph = 2; m_pwr = 1; end
        2: if (acc) ph = 3;
        3: if (orr) begin
             if (idx < 7) begin idx++; m_tx = cur[idx]; end
             else if (lastf) begin ph = 4; m_pwr = 0; m_tx = 0; end
             else if (!s_valid) begin ph = 0; m_pwr = 0; m_tx = 0; m_und = 1; end
           end
        default: ph = 0;
      endcase
      if (acc) begin
        cur = s_data; lastf = s_last; idx = 0; m_tx = s_data[0];
        void'(src_q.pop_front());
      end
    end
  end

  // stream source, driven away from the active edge
  always @(negedge clk) begin
    s_valid <= src_en && (src_q.size() > 0);
    s_data  <= (src_q.size() > 0) ? src_q[0][7:0] : 8'h00;
    s_last  <= (src_q.size() > 0) ? src_q[0][8]   : 1'b0;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (arst_n) begin
      chk("R1/R2 tx_data", tx_data, m_tx);
      chk("R4/R6/R7 tx_pwr_en", tx_pwr_en, m_pwr);
      chk("R5 s_ready", s_ready, r1 && (ph == 2 || (ph == 3 && idx == 7 && !lastf)));
      chk("R7 done_pulse", done_p, ph == 4);
      chk("R3/R8 busy_pulse", busy_p, m_busy);
      chk("R6 underrun_pulse", und_p, m_und);
      chk("R10 bb_rst_n", bb_rst_n, m_bbr);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask
  task automatic push(input logic last, input logic [7:0] b);
    src_q.push_back({23'd0, last, b});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    // R9: reset state
    chk("R9 tx_data", tx_data, 1'b0);
    chk("R9 tx_pwr_en", tx_pwr_en, 1'b0);
    chk("R9 bb_rst_n", bb_rst_n, 1'b0);
    chk("R9 pulses", done_p | busy_p | und_p | s_ready, 1'b0);
    arst_n = 1'b1;
    cyc(3);
    // R10: baseband reset hold
    hold = 1'b1; cyc(4); hold = 1'b0; cyc(3);
    // R3/R8: busy channel aborts
    cca = 1'b1; cyc(4); kick(); cyc(6);
    cca = 1'b0; cyc(4);
    // R1/R4/R5/R7: three-byte packet, ready steady
    rdy = 1'b1; cyc(4);
    push(0, 8'hA5); push(0, 8'h3C); push(1, 8'h81);
    kick(); cyc(10);
    kick();                       // R3: ignored while shifting
    cyc(40);
    // R2/R4: ready withheld at power-up then toggled mid-byte
    rdy = 1'b0; cyc(4);
    push(0, 8'h6E); push(1, 8'hC3);
    kick(); cyc(8);
    rdy = 1'b1; cyc(5); rdy = 1'b0; cyc(4); rdy = 1'b1; cyc(3);
    rdy = 1'b0; cyc(3); rdy = 1'b1; cyc(30);
    // R6: source runs dry after one byte
    push(0, 8'h5A);
    kick(); cyc(25);
    src_en = 1'b0; push(1, 8'h11); cyc(5);
    src_q.delete(); src_en = 1'b1; cyc(3);
    // R1/R7: single-byte packets
    push(1, 8'hFF); kick(); cyc(20);
    push(1, 8'h01); kick(); cyc(20);
    // R9: reset mid-packet
    push(0, 8'hF0); push(1, 8'h0F); kick(); cyc(12);
    arst_n = 1'b0; cyc(1);
    chk("R9 tx_pwr_en in reset", tx_pwr_en, 1'b0);
    chk("R9 tx_data in reset", tx_data, 1'b0);
    src_q.delete(); cyc(2); arst_n = 1'b1; cyc(6);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule